// File: doc/BRIEF.md
# Time-of-Day Counter Core

This block keeps the time of day from a slow tick enable. A sub-second divider counts tick enables. When it wraps, it advances a chain of four wrapping counters: seconds, minutes, hours and day of week. Software sees four word registers behind a small synchronous register port: a control register, the read-only sub-second count, a packed time word and an interrupt flag register. An interrupt line follows the flag register.

Software sets the time in three steps. It stops the counters through the control register, writes the packed time word, and then starts the counters again. Every second that elapses sets a flag. Software clears flags by writing ones to them, so it can read the flag register and write the same value back to clear only the flags it has seen. An external alarm event input sets a second flag. The comparison logic that would produce that event lies outside this block.

Read data is registered. The value of the register selected by `addr` appears on `rdata` one clock after the address is presented. Register selection on `addr`: 0 control, 1 sub-second count, 2 packed time word, 3 flags.

Top module: `rtc_time_core`

## Requirements
- R1: After a synchronous reset, the control register, the sub-second count, every time field and both flags are zero, and `irq` is low.
- R2: While control bit 0 (run) is set, each cycle with `tick_en` high advances the sub-second count by one. After TICKS_PER_SEC-1 the count returns to zero and seconds advance in that same cycle. While run is clear, all counters hold.
- R3: While control bit 1 (tick hold) is set, the sub-second count stays at zero regardless of `tick_en` and run, and seconds do not advance.
- R4: Seconds and minutes wrap from 59 to 0, hours from 23 to 0 and day of week from 6 to 0. Each wrap advances the next field in the same clock cycle.
- R5: The packed time word (address 2) holds seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16 and day of week in bits 26:24. All other bits read as zero.
- R6: A write to the time word loads all four fields only while run is clear. The write is ignored while run is set. A field value above its maximum loads as zero.
- R7: Flag bit 0 (address 3) is set whenever seconds advance. Flag bit 1 is set by a high `alarm_evt`. `irq` is high exactly when at least one flag is set.
- R8: Writing a one to a flag bit clears it. Writing a zero leaves it unchanged.
- R9: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: The sub-second count (address 1) is read-only. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable per sub-second tick |
| alarm_evt | input | 1 | External event that sets the alarm flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
On every cycle, the embedded assertions check the following:
- every field stays within its range and wraps to zero;
- the sub-second count is frozen while stopped and zero while held;
- a set flag survives unless a one is written to it, and a hardware set always lands;
- `irq` matches the flags;
- a time write while running leaves the time word alone.

Only the bench scenarios can show the following:
- the packed bit layout with reserved bits zero;
- the zeroing of out-of-range loads;
- the full 23:59:59 day-6 rollover through every field;
- read-and-write-back clearing of a single flag;
- that writes to the sub-second count are ignored.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;
  localparam int NUM_FIELDS = 4;
  localparam int NUM_FLAGS  = 2;
  localparam int ADDR_W     = 2;
  localparam int DATA_W     = 32;
  localparam int SLOT_W     = 8;

  // field order: seconds, minutes, hours, day of week
  localparam int FLD_LSB [NUM_FIELDS] = '{0, 8, 16, 24};
  localparam int FLD_W   [NUM_FIELDS] = '{6, 6, 5, 3};
  localparam int FLD_MAX [NUM_FIELDS] = '{59, 59, 23, 6};

  localparam int FLAG_INC = 0;
  localparam int FLAG_ALM = 1;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_TICK = 2'd1,
    SEL_TIME = 2'd2,
    SEL_FLAG = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic hold;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int TICKS = 32768,
  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          hold,
  input  logic          tick_en,
  output logic [TW-1:0] cnt,
  output logic          sec_pulse
);
  localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

  logic step;
  assign step      = run && tick_en && !hold;
  assign sec_pulse = step && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // R3
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == '0));

  // R2
  tick_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !hold) |=> $stable(cnt));
endmodule

// File: rtl/rtc_field_cnt.sv
module rtc_field_cnt #(
  parameter int W    = 6,
  parameter int MAXV = 59
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = W'(MAXV);

  assign wrap = inc && (val == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
    end else if (ld) begin
      val <= (ld_val > TOP) ? '0 : ld_val;
    end else if (inc) begin
      val <= (val == TOP) ? '0 : val + 1'b1;
    end
  end

  // R4
  range_chk: assert property (@(posedge clk) disable iff (rst)
    val <= TOP);

  // R4
  rollover_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && val == TOP) |=> (val == '0));
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_nxt;

  // hardware set takes precedence over a same-cycle software clear
  assign flags_nxt = (flags & ~clr) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_nxt;
      irq   <= |flags_nxt;
    end
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((flags & $past(set)) == $past(set)));

  // R8
  keep_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

  // R7
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|flags));
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_core_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  localparam int TICK_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  logic                alarm_evt,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                irq
);
  ctrl_t               ctrl_q;
  logic [TICK_W-1:0]   tick_cnt;
  logic                sec_pulse;
  logic [NUM_FIELDS-1:0] fld_wrap;
  logic [SLOT_W-1:0]   fld_slot [NUM_FIELDS];
  logic [DATA_W-1:0]   time_word;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic                time_ld;
  logic                unused_wdata;
  reg_sel_e            sel;

  assign sel          = reg_sel_e'(addr);
  assign time_ld      = wr_en && (sel == SEL_TIME) && !ctrl_q.run;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && sel == SEL_CTRL) begin
      ctrl_q <= ctrl_t'(wdata[1:0]);
    end
  end

  rtc_tick_div #(.TICKS(TICKS_PER_SEC)) u_div (
    .clk       (clk),
    .rst       (rst),
    .run       (ctrl_q.run),
    .hold      (ctrl_q.hold),
    .tick_en   (tick_en),
    .cnt       (tick_cnt),
    .sec_pulse (sec_pulse)
  );

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    logic [FLD_W[g]-1:0] val;
    logic                inc;
    if (g == 0) begin : g_first
      assign inc = sec_pulse;
    end else begin : g_next
      assign inc = fld_wrap[g-1];
    end
    rtc_field_cnt #(.W(FLD_W[g]), .MAXV(FLD_MAX[g])) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .inc    (inc),
      .ld     (time_ld),
      .ld_val (wdata[FLD_LSB[g] +: FLD_W[g]]),
      .val    (val),
      .wrap   (fld_wrap[g])
    );
    assign fld_slot[g] = SLOT_W'(val);
  end

  always_comb begin
    time_word = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      time_word[FLD_LSB[i] +: SLOT_W] = fld_slot[i];
    end
  end

  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_INC] = sec_pulse;
    flag_set[FLAG_ALM] = alarm_evt;
    flag_clr           = (wr_en && sel == SEL_FLAG) ? wdata[NUM_FLAGS-1:0] : '0;
  end

  rtc_irq_flags #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set   (flag_set),
    .clr   (flag_clr),
    .flags (flag_q),
    .irq   (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (sel)
        SEL_CTRL: rdata <= DATA_W'(ctrl_q);
        SEL_TICK: rdata <= DATA_W'(tick_cnt);
        SEL_TIME: rdata <= time_word;
        SEL_FLAG: rdata <= DATA_W'(flag_q);
        default:  rdata <= '0;
      endcase
    end
  end

  // R6
  run_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_TIME && ctrl_q.run && !sec_pulse) |=> $stable(time_word));

  // R4
  week_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    fld_wrap[NUM_FIELDS-1] |=> (time_word[FLD_LSB[NUM_FIELDS-1] +: SLOT_W] == '0));
endmodule

// File: tb/rtc_time_core_tb_top.sv
`timescale 1ns/1ps
module rtc_time_core_tb_top;
  localparam int TPS = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        alarm_evt = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic rd_req = 1'b0;
  logic finished = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_item_t;
  exp_item_t sb_q[$];

  always #2 clk = ~clk;

  rtc_time_core #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .alarm_evt(alarm_evt),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] pack(int s, int m, int h, int d);
    logic [31:0] w = '0;
    w[5:0]   = 6'(s);
    w[13:8]  = 6'(m);
    w[20:16] = 5'(h);
    w[26:24] = 3'(d);
    return w;
  endfunction

  // driver: present an address and queue the expected read value
  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_item_t it;
    @(negedge clk);
    addr   = a;
    wr_en  = 1'b0;
    rd_req = 1'b1;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // monitor: compare registered read data just after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      if (rd_req) begin
        exp_item_t it;
        #1;
        it = sb_q.pop_front();
        checks++;
        if (rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, 32'h0, "R1 ctrl");
    rd(2'd1, 32'h0, "R1 tick");
    rd(2'd2, 32'h0, "R1 time");
    rd(2'd3, 32'h0, "R1 flags");
    chk_irq(1'b0, "R1 irq");

    // R2 stopped: ticks do nothing
    ticks(5);
    rd(2'd1, 32'h0, "R2 stopped tick");

    // R5/R6 load with junk in reserved bits
    wr(2'd2, pack(58, 59, 23, 6) | 32'hF8E0_C0C0);
    rd(2'd2, pack(58, 59, 23, 6), "R5 packed layout");
    wr(2'd2, pack(61, 5, 0, 0));
    rd(2'd2, pack(0, 5, 0, 0), "R6 out of range loads zero");
    wr(2'd2, pack(58, 59, 23, 6));

    // R2 run
    wr(2'd0, 32'h1);
    rd(2'd0, 32'h1, "R2 ctrl run");
    ticks(15);
    rd(2'd1, 32'd15, "R2 tick count");
    rd(2'd2, pack(58, 59, 23, 6), "R2 no second yet");
    rd(2'd3, 32'h0, "R7 no flag yet");
    ticks(1);
    rd(2'd1, 32'd0, "R2 tick wrap");
    rd(2'd2, pack(59, 59, 23, 6), "R2 second advance");
    rd(2'd3, 32'h1, "R7 increment flag");
    chk_irq(1'b1, "R7 irq set");

    // R6 ignored while running
    wr(2'd2, 32'h0);
    rd(2'd2, pack(59, 59, 23, 6), "R6 write ignored while running");

    // R4 full rollover
    ticks(TPS);
    rd(2'd2, pack(0, 0, 0, 0), "R4 full rollover");

    // R8 clearing
    wr(2'd3, 32'h0);
    rd(2'd3, 32'h1, "R8 zero write keeps flag");
    wr(2'd3, 32'h1);
    rd(2'd3, 32'h0, "R8 one write clears");
    chk_irq(1'b0, "R7 irq clear");

    // R9 simultaneous set and clear
    ticks(TPS - 1);
    @(negedge clk);
    tick_en = 1'b1;
    addr    = 2'd3;
    wdata   = 32'h1;
    wr_en   = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    wr_en   = 1'b0;
    rd(2'd3, 32'h1, "R9 hardware set wins");
    rd(2'd2, pack(1, 0, 0, 0), "R9 second advanced");

    // R7/R8 alarm flag and selective clear
    @(negedge clk);
    alarm_evt = 1'b1;
    @(negedge clk);
    alarm_evt = 1'b0;
    rd(2'd3, 32'h3, "R7 alarm flag");
    wr(2'd3, 32'h2);
    rd(2'd3, 32'h1, "R8 selective clear");
    chk_irq(1'b1, "R7 irq remaining flag");
    wr(2'd3, 32'h1);
    chk_irq(1'b0, "R7 irq all clear");

    // R3 tick hold
    wr(2'd0, 32'h3);
    ticks(20);
    rd(2'd1, 32'd0, "R3 held at zero");
    rd(2'd2, pack(1, 0, 0, 0), "R3 seconds unchanged");
    wr(2'd0, 32'h1);
    ticks(3);
    rd(2'd1, 32'd3, "R3 counts after release");

    // R10 read-only tick
    wr(2'd1, 32'h7);
    rd(2'd1, 32'd3, "R10 tick write ignored");

    // R2 stop holds
    wr(2'd0, 32'h0);
    ticks(5);
    rd(2'd1, 32'd3, "R2 stop holds tick");
    rd(2'd0, 32'h0, "R2 ctrl cleared");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule